// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block sits beside the byte-wide data path of a NAND flash interface and snoops every byte that crosses it. While calculation is enabled it folds each byte into single-error-correcting Hamming parity. A 512-byte sector is handled as two separate 256-byte groups, and each group yields two line-parity bytes and one column-parity byte. The host compares this parity with the parity stored in the spare area. The host also does the syndrome work and the bit repair. Strobe timing belongs to the bus bridge.

Software steers the block with writes to the interface mode register. One command clears the parity. The dummy data read that must follow the clear is swallowed. A second command starts accumulation. A third switches the data port so that it returns the six parity bytes as three 16-bit words, in an interleaved order. A fourth command gives the port back to normal data traffic. Any other mode code has no effect on the block.

Top module: `nand_ecc_accum`

## Requirements
- R1: Reset, and a mode write of 0xF4, both clear all parity. After a clear the three result words read 0x0000, 0x0003 and 0x0300.
- R2: After a 0xF4 write, the next byte on the data path is never accumulated. This holds in every mode.
- R3: Bytes are accumulated only after a 0xB4 mode write. Bytes seen in any other mode leave the parity unchanged.
- R4: Accumulated bytes are counted from 0. Bytes 0..255 update group 0 and bytes 256..511 update group 1, using index = count mod 256.
- R5: Line parity LP[2k] is the XOR of the parity of every byte whose index bit k is 0. LP[2k+1] is the same XOR over bytes whose index bit k is 1. k runs from 0 to 7.
- R6: The column byte of a group is {CP5..CP0, 2'b11}. CP[2j] is the XOR of all data bits whose bit position has bit j equal to 0, and CP[2j+1] covers those with bit j equal to 1. j runs from 0 to 2.
- R7: A 0xD4 write raises ecc_sel_o. The result words then read in a fixed order. Word 0 is {g0 LP15..8, g0 LP7..0}. Word 1 is {g1 LP7..0, g0 column}. Word 2 is {g1 column, g1 LP15..8}. The bit positions are high byte then low byte.
- R8: Each rd_i pulse while in result mode moves the read pointer on by one. After word 2 it goes back to word 0.
- R9: Once 512 bytes have been accumulated, all further bytes are ignored until the next clear.
- R10: A 0x94 write drops ecc_sel_o and forces ecc_o to zero. A later 0xD4 write starts the read-back at word 0.
- R11: A mode write of any other code changes neither the mode nor the accumulation.
- R12: Flipping one bit of one byte toggles exactly one bit of each LP pair and each CP pair in that byte's group. It leaves the other group's parity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_i | input | 8 | Mode code being written |
| data_valid_i | input | 1 | A byte crosses the data path this cycle |
| data_i | input | 8 | Byte on the data path |
| rd_i | input | 1 | 16-bit read of the data port |
| ecc_sel_o | output | 1 | Data port returns parity words |
| ecc_o | output | 16 | Current parity word, zero outside result mode |

## Verification
On every cycle the assertions check the following: a clear really zeroes both groups, the swallowed dummy byte and any byte past the sector end leave the parity still, the count never passes 512, and the mode commands move the result select and the read pointer as required. Only the bench scenarios can show that the parity values are right. These cover the exact line and column parity for several data patterns, the interleaved word order, and the single-bit-flip signature. They also show that ignored bytes, unknown codes and data-mode traffic leave the values that are read back unchanged.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int HALF_BYTES   = 256;
  localparam int HALVES       = 2;
  localparam int IDX_W        = $clog2(HALF_BYTES);
  localparam int LP_W         = 2 * IDX_W;
  localparam int SECTOR_BYTES = HALVES * HALF_BYTES;
  localparam int CNT_W        = $clog2(SECTOR_BYTES) + 1;
  localparam int RES_WORDS    = 3;
  localparam int PTR_W        = 2;

  localparam logic [7:0] CMD_ECC_CLR = 8'hF4;
  localparam logic [7:0] CMD_ECC_RUN = 8'hB4;
  localparam logic [7:0] CMD_ECC_RES = 8'hD4;
  localparam logic [7:0] CMD_DATA    = 8'h94;

  typedef enum logic [1:0] {
    ST_DATA,
    ST_CALC,
    ST_RES,
    ST_HOLD
  } ecc_mode_e;
endpackage

// File: rtl/nand_ecc_half.sv
module nand_ecc_half
  import nand_ecc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [LP_W-1:0]  lp_o,
  output logic [7:0]       col_o
);
  logic [LP_W-1:0] lp_q, lp_d;
  logic [7:0]      colx_q;
  logic            bpar;

  assign bpar = ^byte_i;

  always_comb begin
    lp_d = lp_q;
    for (int k = 0; k < IDX_W; k++) begin
      if (idx_i[k]) lp_d[2*k+1] = lp_q[2*k+1] ^ bpar;
      else          lp_d[2*k]   = lp_q[2*k]   ^ bpar;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q   <= '0;
      colx_q <= '0;
    end else if (clr_i) begin
      lp_q   <= '0;
      colx_q <= '0;
    end else if (en_i) begin
      lp_q   <= lp_d;
      colx_q <= colx_q ^ byte_i;
    end
  end

  // column parity is linear: derive from running XOR of all bytes
  always_comb begin
    logic [5:0] cp;
    cp = '0;
    for (int j = 0; j < 3; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) != 0) cp[2*j+1] = cp[2*j+1] ^ colx_q[b];
        else                     cp[2*j]   = cp[2*j]   ^ colx_q[b];
      end
    end
    col_o = {cp, 2'b11};
  end

  assign lp_o = lp_q;
endmodule

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [7:0]       mode_i,
  input  logic             data_valid_i,
  input  logic             rd_i,
  output logic             clr_o,
  output logic             acc_en_o,
  output logic             half_sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             res_mode_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             skip_o
);
  ecc_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic             skip_q;

  assign clr_o    = mode_wr_i && (mode_i == CMD_ECC_CLR);
  assign acc_en_o = data_valid_i && (mode_q == ST_CALC) && !skip_q && !clr_o &&
                    (cnt_q < CNT_W'(SECTOR_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ST_DATA;
      cnt_q  <= '0;
      ptr_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      if (data_valid_i && skip_q) skip_q <= 1'b0;
      if (acc_en_o) cnt_q <= cnt_q + 1'b1;
      if (rd_i && mode_q == ST_RES)
        ptr_q <= (ptr_q == PTR_W'(RES_WORDS - 1)) ? '0 : ptr_q + 1'b1;
      if (mode_wr_i) begin
        unique case (mode_i)
          CMD_ECC_CLR: begin
            mode_q <= ST_HOLD;
            cnt_q  <= '0;
            skip_q <= 1'b1;
          end
          CMD_ECC_RUN: mode_q <= ST_CALC;
          CMD_ECC_RES: begin
            mode_q <= ST_RES;
            ptr_q  <= '0;
          end
          CMD_DATA: begin
            mode_q <= ST_DATA;
            ptr_q  <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign half_sel_o = cnt_q[IDX_W];
  assign idx_o      = cnt_q[IDX_W-1:0];
  assign res_mode_o = (mode_q == ST_RES);
  assign ptr_o      = ptr_q;
  assign cnt_o      = cnt_q;
  assign skip_o     = skip_q;
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_wr_i,
  input  logic [7:0]  mode_i,
  input  logic        data_valid_i,
  input  logic [7:0]  data_i,
  input  logic        rd_i,
  output logic        ecc_sel_o,
  output logic [15:0] ecc_o
);
  logic             clr, acc_en, half_sel, res_mode, skip_pend;
  logic [IDX_W-1:0] byte_idx;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] byte_cnt;
  logic [LP_W-1:0]  half_lp  [HALVES];
  logic [7:0]       half_col [HALVES];
  logic [15:0]      word;

  nand_ecc_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_wr_i    (mode_wr_i),
    .mode_i       (mode_i),
    .data_valid_i (data_valid_i),
    .rd_i         (rd_i),
    .clr_o        (clr),
    .acc_en_o     (acc_en),
    .half_sel_o   (half_sel),
    .idx_o        (byte_idx),
    .res_mode_o   (res_mode),
    .ptr_o        (rd_ptr),
    .cnt_o        (byte_cnt),
    .skip_o       (skip_pend)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    nand_ecc_half u_half (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (acc_en && (half_sel == 1'(h))),
      .idx_i  (byte_idx),
      .byte_i (data_i),
      .lp_o   (half_lp[h]),
      .col_o  (half_col[h])
    );
  end

  // interleaved read-back order
  always_comb begin
    unique case (rd_ptr)
      2'd0:    word = half_lp[0];
      2'd1:    word = {half_lp[1][7:0], half_col[0]};
      2'd2:    word = {half_col[1], half_lp[1][15:8]};
      default: word = '0;
    endcase
  end

  assign ecc_sel_o = res_mode;
  assign ecc_o     = res_mode ? word : 16'h0000;
endmodule

// File: rtl/nand_ecc_accum_chk.sv
module nand_ecc_accum_chk
  import nand_ecc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_wr_i,
  input logic [7:0]       mode_i,
  input logic             data_valid_i,
  input logic             rd_i,
  input logic             ecc_sel_o,
  input logic [PTR_W-1:0] ptr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             skip_i,
  input logic [LP_W-1:0]  lp0_i,
  input logic [LP_W-1:0]  lp1_i,
  input logic [7:0]       col0_i,
  input logic [7:0]       col1_i
);
  logic known_cmd;
  assign known_cmd = (mode_i == CMD_ECC_CLR) || (mode_i == CMD_ECC_RUN) ||
                     (mode_i == CMD_ECC_RES) || (mode_i == CMD_DATA);

  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_i == CMD_ECC_CLR |=>
      lp0_i == '0 && lp1_i == '0 && col0_i == 8'h03 && col1_i == 8'h03);

  p_skip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_i && data_valid_i && !mode_wr_i |=>
      $stable(lp0_i) && $stable(lp1_i) && $stable(col0_i) && $stable(col1_i) && !skip_i);

  p_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_i == CMD_ECC_RES |=> ecc_sel_o && ptr_i == '0);

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ecc_sel_o && !mode_wr_i && ptr_i == PTR_W'(RES_WORDS - 1) |=> ptr_i == '0);

  p_ptr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_i < PTR_W'(RES_WORDS));

  p_cnt_max_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(SECTOR_BYTES));

  p_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == CNT_W'(SECTOR_BYTES) && !mode_wr_i |=>
      $stable(lp0_i) && $stable(lp1_i) && $stable(col0_i) && $stable(col1_i));

  p_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_i == CMD_DATA |=> !ecc_sel_o);

  p_other_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && !known_cmd |=> $stable(ecc_sel_o));
endmodule

bind nand_ecc_accum nand_ecc_accum_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_wr_i    (mode_wr_i),
  .mode_i       (mode_i),
  .data_valid_i (data_valid_i),
  .rd_i         (rd_i),
  .ecc_sel_o    (ecc_sel_o),
  .ptr_i        (rd_ptr),
  .cnt_i        (byte_cnt),
  .skip_i       (skip_pend),
  .lp0_i        (half_lp[0]),
  .lp1_i        (half_lp[1]),
  .col0_i       (half_col[0]),
  .col1_i       (half_col[1])
);

// File: tb/nand_ecc_accum_bench.sv
`timescale 1ns/1ps
module nand_ecc_accum_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_wr_i = 1'b0;
  logic [7:0]  mode_i = 8'h00;
  logic        data_valid_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic        rd_i = 1'b0;
  logic        ecc_sel_o;
  logic [15:0] ecc_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] sec [0:519];

  always #2.5 clk = ~clk;

  nand_ecc_accum u_nand_ecc_accum (
    .clk_i(clk), .rst_ni(rst_ni), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .data_valid_i(data_valid_i), .data_i(data_i), .rd_i(rd_i),
    .ecc_sel_o(ecc_sel_o), .ecc_o(ecc_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_wr_i = 1'b1; mode_i = v;
    @(negedge clk); mode_wr_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); data_valid_i = 1'b1; data_i = b;
    @(negedge clk); data_valid_i = 1'b0;
  endtask

  task automatic stream(input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk); data_valid_i = 1'b1; data_i = sec[i];
    end
    @(negedge clk); data_valid_i = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] w);
    @(negedge clk); w = ecc_o; rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic read3(output logic [15:0] w0, output logic [15:0] w1, output logic [15:0] w2);
    wr_mode(8'hD4);
    rd_word(w0); rd_word(w1); rd_word(w2);
  endtask

  // independent parity model over sec[base +: 256]
  task automatic model_half(input int base, output logic [15:0] lp, output logic [7:0] col);
    logic [5:0] cp;
    lp = '0; cp = '0;
    for (int i = 0; i < 256; i++) begin
      logic p;
      p = ^sec[base+i];
      for (int k = 0; k < 8; k++)
        if (i[k]) lp[2*k+1] ^= p; else lp[2*k] ^= p;
      for (int c = 0; c < 8; c++)
        for (int j = 0; j < 3; j++)
          if (c[j]) cp[2*j+1] ^= sec[base+i][c]; else cp[2*j] ^= sec[base+i][c];
    end
    col = {cp, 2'b11};
  endtask

  task automatic model_words(output logic [15:0] w0, output logic [15:0] w1, output logic [15:0] w2);
    logic [15:0] lp0, lp1;
    logic [7:0]  c0, c1;
    model_half(0, lp0, c0);
    model_half(256, lp1, c1);
    w0 = lp0;
    w1 = {lp1[7:0], c0};
    w2 = {c1, lp1[15:8]};
  endtask

  task automatic run_sector(input string req);
    logic [15:0] a0, a1, a2, e0, e1, e2;
    wr_mode(8'hF4); push(8'h5A); wr_mode(8'hB4);
    stream(0, 512);
    read3(a0, a1, a2);
    model_words(e0, e1, e2);
    chk({req, " word0"}, a0, e0);
    chk({req, " word1"}, a1, e1);
    chk({req, " word2"}, a2, e2);
  endtask

  task automatic t_reset;
    logic [15:0] a0, a1, a2;
    chk("R10 sel low after reset", {15'd0, ecc_sel_o}, 16'd0);
    chk("R10 ecc_o zero after reset", ecc_o, 16'h0000);
    read3(a0, a1, a2);
    chk("R7 sel high in result mode", {15'd0, ecc_sel_o}, 16'd1);
    chk("R1 reset word0", a0, 16'h0000);
    chk("R1 reset word1", a1, 16'h0003);
    chk("R1 reset word2", a2, 16'h0300);
    wr_mode(8'h94);
  endtask

  task automatic t_patterns;
    for (int i = 0; i < 520; i++) sec[i] = 8'h00;
    sec[0] = 8'h01;
    run_sector("R5 R6 R7 lone bit at byte 0");
    for (int i = 0; i < 520; i++) sec[i] = 8'h00;
    sec[511] = 8'h80;
    run_sector("R4 R5 R6 lone bit at byte 511");
    for (int i = 0; i < 520; i++) sec[i] = 8'(i);
    run_sector("R3 R4 R5 R6 ramp");
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 520; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        sec[i] = lf[7:0];
      end
    end
    run_sector("R3 R4 R5 R6 lfsr");
  endtask

  task automatic t_known_values;
    logic [15:0] a0, a1, a2;
    for (int i = 0; i < 520; i++) sec[i] = 8'h00;
    sec[511] = 8'h80;
    wr_mode(8'hF4); push(8'h00); wr_mode(8'hB4); stream(0, 512);
    read3(a0, a1, a2);
    chk("R5 R7 hand value word0", a0, 16'h0000);
    chk("R6 R7 hand value word1", a1, 16'hAA03);
    chk("R6 R7 hand value word2", a2, 16'hABAA);
  endtask

  task automatic t_skip;
    logic [15:0] a0, a1, a2, e0, e1, e2;
    for (int i = 0; i < 520; i++) sec[i] = 8'(i * 3 + 1);
    wr_mode(8'hF4); wr_mode(8'hB4);
    push(8'hA5);
    stream(0, 512);
    read3(a0, a1, a2);
    model_words(e0, e1, e2);
    chk("R2 dummy skipped word0", a0, e0);
    chk("R2 dummy skipped word1", a1, e1);
    chk("R2 dummy skipped word2", a2, e2);
  endtask

  task automatic t_overflow;
    logic [15:0] a0, a1, a2, e0, e1, e2;
    for (int i = 0; i < 520; i++) sec[i] = 8'(i ^ 8'h3C);
    wr_mode(8'hF4); push(8'h00); wr_mode(8'hB4);
    stream(0, 520);
    read3(a0, a1, a2);
    model_words(e0, e1, e2);
    chk("R9 extra bytes word0", a0, e0);
    chk("R9 extra bytes word1", a1, e1);
    chk("R9 extra bytes word2", a2, e2);
  endtask

  task automatic t_wrap;
    logic [15:0] a0, a1, a2, a3, b0;
    read3(a0, a1, a2);
    rd_word(a3);
    chk("R8 fourth read wraps", a3, a0);
    rd_word(a3);
    chk("R8 fifth read is word1", a3, a1);
    wr_mode(8'hD4);
    rd_word(b0);
    chk("R10 D4 restarts at word0", b0, a0);
  endtask

  task automatic t_data_mode;
    logic [15:0] a0, a1, a2, e0, e1, e2;
    model_words(e0, e1, e2);
    wr_mode(8'h94);
    chk("R10 sel low in data mode", {15'd0, ecc_sel_o}, 16'd0);
    chk("R10 ecc_o zero in data mode", ecc_o, 16'h0000);
    push(8'hFF); push(8'h7E);
    read3(a0, a1, a2);
    chk("R3 data mode bytes ignored word0", a0, e0);
    chk("R3 data mode bytes ignored word1", a1, e1);
    chk("R3 data mode bytes ignored word2", a2, e2);
  endtask

  task automatic t_other_code;
    logic [15:0] a0, a1, a2, e0, e1, e2;
    for (int i = 0; i < 520; i++) sec[i] = 8'(8'hC3 - i);
    wr_mode(8'hF4); push(8'h00); wr_mode(8'hB4);
    stream(0, 256);
    wr_mode(8'h55);
    stream(256, 512);
    read3(a0, a1, a2);
    model_words(e0, e1, e2);
    chk("R11 unknown code ignored word0", a0, e0);
    chk("R11 unknown code ignored word1", a1, e1);
    chk("R11 unknown code ignored word2", a2, e2);
    wr_mode(8'h12);
    chk("R11 unknown code keeps result mode", {15'd0, ecc_sel_o}, 16'd1);
  endtask

  task automatic t_flip;
    logic [15:0] a0, a1, a2, b0, b1, b2;
    logic [15:0] lpd;
    logic [7:0]  cd;
    for (int i = 0; i < 520; i++) sec[i] = 8'(i * 13 + 7);
    run_sector("R12 baseline");
    wr_mode(8'hD4); rd_word(a0); rd_word(a1); rd_word(a2);
    sec[300] = sec[300] ^ 8'h20;
    wr_mode(8'hF4); push(8'h00); wr_mode(8'hB4); stream(0, 512);
    read3(b0, b1, b2);
    chk("R12 group0 LP unchanged", b0, a0);
    chk("R12 group0 column unchanged", {8'h00, b1[7:0]}, {8'h00, a1[7:0]});
    lpd = {b2[7:0], b1[15:8]} ^ {a2[7:0], a1[15:8]};
    cd  = b2[15:8] ^ a2[15:8];
    chk("R12 one LP bit per pair", 16'($countones(lpd)), 16'd8);
    for (int k = 0; k < 8; k++)
      chk("R12 LP pair toggles once", {15'd0, lpd[2*k] ^ lpd[2*k+1]}, 16'd1);
    chk("R12 one CP bit per pair", 16'($countones(cd)), 16'd3);
    chk("R12 CP low bits stay", {14'd0, cd[1:0]}, 16'd0);
  endtask

  task automatic t_clear;
    logic [15:0] a0, a1, a2;
    wr_mode(8'hF4);
    read3(a0, a1, a2);
    chk("R1 clear word0", a0, 16'h0000);
    chk("R1 clear word1", a1, 16'h0003);
    chk("R1 clear word2", a2, 16'h0300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_known_values();
    t_skip();
    t_overflow();
    t_wrap();
    t_data_mode();
    t_other_code();
    t_flip();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule